// File: doc/BRIEF.md
# ATA Task-File Command Issuer

This block hands one single-sector command to an ATA device over an 8-bit task-file register port, using 28-bit logical block addressing. A host pulses `start` with a block address and an opcode (0x20 read sector, 0x30 write sector, 0xEC identify). The block first polls the status register until the device is not busy. It then loads the address registers and writes the opcode. After that it polls status again until the device accepts the command.

Each status read is separated from the next by a fixed wait. That wait is a cycle count derived from the clock frequency and a poll interval in microseconds. A per-run poll limit turns a device that stays busy into a timeout instead of a hang. A device fault reported while the device is busy ends the command with a fault. Completion needs only the busy flag to clear; the data-request flag is never waited on. Moving sector data and looping over several sectors belong to other blocks.

Top module: `ata_cmd_issuer`

## Requirements
- R1: After reset `busy`, `regRd`, `regWr`, `done`, `faultErr` and `timeoutErr` are all low.
- R2: After an accepted `start`, the block reads status (register address 7) and makes no register write until a status read shows bit 7 (busy) clear.
- R3: Two consecutive status reads within one poll phase are exactly POLL_CYCLES+1 clocks apart, where POLL_CYCLES = CLK_HZ/1000000*POLL_US.
- R4: Once the device is not busy, the block makes exactly six writes on consecutive clocks, in this order: address 2 data 0x01; address 3 LBA[7:0]; address 4 LBA[15:8]; address 5 LBA[23:16]; address 6 0xE0 OR LBA[27:24]; address 7 the opcode.
- R5: When the opcode is 0xEC (identify), the address bytes are written as if LBA were zero, whatever `lba` holds.
- R6: After the opcode write, status is polled until bit 7 is clear, and then `done` pulses. Bit 3 (data request) has no effect on completion.
- R7: A post-command status read with bit 7 and bit 5 (device fault) both set ends the command with a `faultErr` pulse and no further reads.
- R8: If `pollLimit` consecutive status reads in one phase all show busy, `timeoutErr` pulses. A timeout in the first phase produces no register write.
- R9: A `start` pulse while `busy` is high is ignored: it changes neither the written values nor the number of completions.
- R10: `done`, `faultErr` and `timeoutErr` are single-cycle pulses, at most one of them is high at a time, and `busy` is low in the cycle a pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to issue one command |
| lba | input | 28 | Logical block address, captured at start |
| opcode | input | 8 | Command byte, captured at start |
| pollLimit | input | 16 | Busy reads allowed per poll phase before timeout |
| regAddr | output | 3 | Task-file register address |
| regWrData | output | 8 | Data for a register write |
| regWr | output | 1 | Register write strobe |
| regRd | output | 1 | Register read strobe |
| regRdData | input | 8 | Register read data, sampled on the clock edge where regRd is high |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Pulse: device accepted the command |
| faultErr | output | 1 | Pulse: device fault seen while busy |
| timeoutErr | output | 1 | Pulse: poll limit reached |

## Verification
The assertions assume the device port answers a read in the same cycle, so `regRdData` is valid at the edge where `regRd` is high. They also assume `pollLimit` is at least one and stays stable during a command. The bench keeps to both assumptions. Its device model drives status combinationally from counters of remaining busy reads. Every run uses a limit between 3 and 6, set before `start` and held until the result pulse.

// File: rtl/ata_issuer_pkg.sv
package ata_issuer_pkg;
  localparam logic [2:0] ADDR_SECCNT = 3'd2;
  localparam logic [2:0] ADDR_STATUS = 3'd7;
  localparam int BIT_BSY = 7;
  localparam int BIT_DF  = 5;
  localparam logic [7:0] OP_IDENTIFY = 8'hEC;
  localparam int NUM_WRITES = 6;

  typedef struct packed {
    logic capture;
    logic idxClr;
    logic idxInc;
    logic rdSel;
    logic delayLoad;
    logic delayDec;
    logic pollClr;
    logic pollInc;
  } ctrl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE_RD, ST_PRE_WAIT, ST_WRITE, ST_POST_RD, ST_POST_WAIT
  } state_t;
endpackage

// File: rtl/ata_issuer_dp.sv
module ata_issuer_dp
  import ata_issuer_pkg::*;
#(
  parameter int POLL_CYCLES = 50000,
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              ctrl,
  input  logic [27:0]        lbaIn,
  input  logic [7:0]         opIn,
  input  logic [LIMIT_W-1:0] pollLimit,
  output logic [2:0]         regAddr,
  output logic [7:0]         regWrData,
  output logic               lastWrite,
  output logic               delayZero,
  output logic               pollLast
);
  localparam int DELAY_W = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
  localparam int IDX_W = $clog2(NUM_WRITES);
  localparam logic [DELAY_W-1:0] DELAY_RELOAD = DELAY_W'(POLL_CYCLES - 1);

  logic [27:0]        lbaQ;
  logic [7:0]         opQ;
  logic [IDX_W-1:0]   idxQ;
  logic [DELAY_W-1:0] delayQ;
  logic [LIMIT_W-1:0] pollQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lbaQ <= '0;
      opQ  <= '0;
    end else if (ctrl.capture) begin
      lbaQ <= (opcode_is_identify(opIn)) ? 28'd0 : lbaIn;
      opQ  <= opIn;
    end
  end

  function automatic logic opcode_is_identify(input logic [7:0] op);
    return op == OP_IDENTIFY;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idxQ <= '0;
    else if (ctrl.idxClr) idxQ <= '0;
    else if (ctrl.idxInc) idxQ <= idxQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) delayQ <= '0;
    else if (ctrl.delayLoad) delayQ <= DELAY_RELOAD;
    else if (ctrl.delayDec) delayQ <= delayQ - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pollQ <= '0;
    else if (ctrl.pollClr) pollQ <= '0;
    else if (ctrl.pollInc) pollQ <= pollQ + 1'b1;
  end

  assign delayZero = (delayQ == '0);
  assign lastWrite = (idxQ == IDX_W'(NUM_WRITES - 1));
  assign pollLast  = ({1'b0, pollQ} + 1'b1) >= {1'b0, pollLimit};

  always_comb begin
    regAddr = ctrl.rdSel ? ADDR_STATUS : (ADDR_SECCNT + 3'(idxQ));
    unique case (idxQ)
      IDX_W'(0): regWrData = 8'h01;
      IDX_W'(1): regWrData = lbaQ[7:0];
      IDX_W'(2): regWrData = lbaQ[15:8];
      IDX_W'(3): regWrData = lbaQ[23:16];
      IDX_W'(4): regWrData = {4'hE, lbaQ[27:24]};
      default:   regWrData = opQ;
    endcase
  end
endmodule

// File: rtl/ata_issuer_ctl.sv
module ata_issuer_ctl
  import ata_issuer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] statusByte,
  input  logic       lastWrite,
  input  logic       delayZero,
  input  logic       pollLast,
  output ctrl_t      ctrl,
  output logic       regRd,
  output logic       regWr,
  output logic       busy,
  output logic       done,
  output logic       faultErr,
  output logic       timeoutErr
);
  state_t stateQ, stateD;
  logic doneD, faultD, timeoutD;
  logic devBusy, devFault;

  assign devBusy  = statusByte[BIT_BSY];
  assign devFault = statusByte[BIT_DF];

  always_comb begin
    stateD   = stateQ;
    ctrl     = '0;
    regRd    = 1'b0;
    regWr    = 1'b0;
    doneD    = 1'b0;
    faultD   = 1'b0;
    timeoutD = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (start) begin
        ctrl.capture = 1'b1;
        ctrl.idxClr  = 1'b1;
        ctrl.pollClr = 1'b1;
        stateD = ST_PRE_RD;
      end
      ST_PRE_RD: begin
        regRd = 1'b1;
        ctrl.rdSel = 1'b1;
        if (!devBusy) begin
          ctrl.pollClr = 1'b1;
          stateD = ST_WRITE;
        end else if (pollLast) begin
          timeoutD = 1'b1;
          stateD = ST_IDLE;
        end else begin
          ctrl.pollInc = 1'b1;
          ctrl.delayLoad = 1'b1;
          stateD = ST_PRE_WAIT;
        end
      end
      ST_PRE_WAIT: begin
        if (delayZero) stateD = ST_PRE_RD;
        else ctrl.delayDec = 1'b1;
      end
      ST_WRITE: begin
        regWr = 1'b1;
        if (lastWrite) stateD = ST_POST_RD;
        else ctrl.idxInc = 1'b1;
      end
      ST_POST_RD: begin
        regRd = 1'b1;
        ctrl.rdSel = 1'b1;
        if (!devBusy) begin
          doneD = 1'b1;
          stateD = ST_IDLE;
        end else if (devFault) begin
          faultD = 1'b1;
          stateD = ST_IDLE;
        end else if (pollLast) begin
          timeoutD = 1'b1;
          stateD = ST_IDLE;
        end else begin
          ctrl.pollInc = 1'b1;
          ctrl.delayLoad = 1'b1;
          stateD = ST_POST_WAIT;
        end
      end
      ST_POST_WAIT: begin
        if (delayZero) stateD = ST_POST_RD;
        else ctrl.delayDec = 1'b1;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      done       <= 1'b0;
      faultErr   <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      stateQ     <= stateD;
      done       <= doneD;
      faultErr   <= faultD;
      timeoutErr <= timeoutD;
    end
  end

  assign busy = (stateQ != ST_IDLE);
endmodule

// File: rtl/ata_cmd_issuer.sv
module ata_cmd_issuer
  import ata_issuer_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int POLL_US = 1000,
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [27:0]        lba,
  input  logic [7:0]         opcode,
  input  logic [LIMIT_W-1:0] pollLimit,
  output logic [2:0]         regAddr,
  output logic [7:0]         regWrData,
  output logic               regWr,
  output logic               regRd,
  input  logic [7:0]         regRdData,
  output logic               busy,
  output logic               done,
  output logic               faultErr,
  output logic               timeoutErr
);
  localparam int POLL_CYCLES = CLK_HZ / 1_000_000 * POLL_US;

  ctrl_t ctrl;
  logic lastWrite, delayZero, pollLast;

  ata_issuer_ctl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .statusByte(regRdData),
    .lastWrite(lastWrite), .delayZero(delayZero), .pollLast(pollLast),
    .ctrl(ctrl), .regRd(regRd), .regWr(regWr), .busy(busy),
    .done(done), .faultErr(faultErr), .timeoutErr(timeoutErr)
  );

  ata_issuer_dp #(.POLL_CYCLES(POLL_CYCLES), .LIMIT_W(LIMIT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .lbaIn(lba), .opIn(opcode),
    .pollLimit(pollLimit), .regAddr(regAddr), .regWrData(regWrData),
    .lastWrite(lastWrite), .delayZero(delayZero), .pollLast(pollLast)
  );
endmodule

// File: rtl/ata_issuer_chk.sv
module ata_issuer_chk #(
  parameter int LIMIT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [27:0]        lba,
  input logic [7:0]         opcode,
  input logic [LIMIT_W-1:0] pollLimit,
  input logic [2:0]         regAddr,
  input logic [7:0]         regWrData,
  input logic               regWr,
  input logic               regRd,
  input logic [7:0]         regRdData,
  input logic               busy,
  input logic               done,
  input logic               faultErr,
  input logic               timeoutErr
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!regRd && !regWr)); // R1
  AST_READ_STATUS_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    regRd |-> (regAddr == 3'd7 && !regWr)); // R2
  AST_WRITE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    regWr |-> (regAddr >= 3'd2)); // R4
  AST_CMD_THEN_POLL: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 3'd7) |=> (regRd && regAddr == 3'd7)); // R6
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(regRd && !regRdData[7])); // R6
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    faultErr |-> $past(regRd && regRdData[7] && regRdData[5])); // R7
  AST_TIMEOUT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> $past(regRd && regRdData[7])); // R8
  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, faultErr, timeoutErr})); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (done || faultErr || timeoutErr) |-> !busy); // R10
endmodule

bind ata_cmd_issuer ata_issuer_chk #(.LIMIT_W(LIMIT_W)) u_chk (.*);

// File: tb/ata_cmd_issuer_tb.sv
module ata_cmd_issuer_tb;
  localparam int POLL_CYC = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [27:0] lba = '0;
  logic [7:0] opcode = '0;
  logic [15:0] pollLimit = 16'd4;
  logic [2:0] regAddr;
  logic [7:0] regWrData;
  logic regWr, regRd, busy, done, faultErr, timeoutErr;
  logic [7:0] regRdData;

  always #10 clk = ~clk;

  ata_cmd_issuer #(.CLK_HZ(50_000_000), .POLL_US(1)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .lba(lba), .opcode(opcode),
    .pollLimit(pollLimit), .regAddr(regAddr), .regWrData(regWrData),
    .regWr(regWr), .regRd(regRd), .regRdData(regRdData), .busy(busy),
    .done(done), .faultErr(faultErr), .timeoutErr(timeoutErr)
  );

  int checks = 0;
  int failures = 0;

  // device model
  int cyc = 0;
  int preLeft, postLeft, rdPre, rdPost, lastRd, wrCount, resCount;
  bit cmdSeen, dfEn, drq, gapBad, busyAtRes;
  int dfAt;
  logic [2:0] wrA [0:15];
  logic [7:0] wrD [0:15];
  logic bsyNow, dfNow;

  always_comb begin
    bsyNow = cmdSeen ? (postLeft > 0) : (preLeft > 0);
    dfNow  = cmdSeen && dfEn && bsyNow && (rdPost >= dfAt);
    regRdData = {bsyNow, !bsyNow, dfNow, 1'b0, drq, 3'b000};
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (regWr) begin
      if (wrCount < 16) begin
        wrA[wrCount] <= regAddr;
        wrD[wrCount] <= regWrData;
      end
      wrCount <= wrCount + 1;
      if (regAddr == 3'd7) begin
        cmdSeen <= 1'b1;
        lastRd <= -1;
      end
    end
    if (regRd) begin
      if (lastRd >= 0 && (cyc - lastRd) != POLL_CYC + 1) gapBad <= 1'b1;
      lastRd <= cyc;
      if (cmdSeen) begin
        rdPost <= rdPost + 1;
        if (postLeft > 0) postLeft <= postLeft - 1;
      end else begin
        rdPre <= rdPre + 1;
        if (preLeft > 0) preLeft <= preLeft - 1;
      end
    end
    if (done || faultErr || timeoutErr) begin
      resCount <= resCount + 1;
      if (busy) busyAtRes <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input int i, input logic [27:0] a,
                                         input logic [7:0] op);
    case (i)
      0: return 8'h01;
      1: return a[7:0];
      2: return a[15:8];
      3: return a[23:16];
      4: return 8'hE0 | {4'h0, a[27:24]};
      default: return op;
    endcase
  endfunction

  // result codes: 1 done, 2 fault, 3 timeout
  task automatic runCmd(input logic [7:0] op, input logic [27:0] a,
                        input int preB, input int postB, input bit dfE,
                        input int dfA, input int lim, input bit drqV,
                        input bit restart);
    int expRes, expPre, expPost, expWr, gotRes, waitCnt;
    logic [27:0] effA;
    @(negedge clk);
    preLeft = preB; postLeft = postB; rdPre = 0; rdPost = 0; lastRd = -1;
    wrCount = 0; resCount = 0; cmdSeen = 0; dfEn = dfE; dfAt = dfA;
    drq = drqV; gapBad = 0; busyAtRes = 0;
    pollLimit = 16'(lim); opcode = op; lba = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      repeat (3) @(negedge clk);
      lba = ~a; opcode = 8'h30; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    gotRes = 0; waitCnt = 0;
    while (gotRes == 0 && waitCnt < 5000) begin
      if (done) gotRes = 1;
      else if (faultErr) gotRes = 2;
      else if (timeoutErr) gotRes = 3;
      else begin
        @(negedge clk);
        waitCnt++;
      end
    end
    effA = (op == 8'hEC) ? 28'd0 : a;
    if (preB >= lim) begin
      expRes = 3; expPre = lim; expPost = 0; expWr = 0;
    end else begin
      expPre = preB + 1; expWr = 6;
      if (dfE && dfA < postB && dfA < lim) begin
        expRes = 2; expPost = dfA + 1;
      end else if (postB >= lim) begin
        expRes = 3; expPost = lim;
      end else begin
        expRes = 1; expPost = postB + 1;
      end
    end
    repeat (10) @(negedge clk);
    chk(gotRes == expRes, expRes == 1 ? "R6" : (expRes == 2 ? "R7" : "R8"),
        "result", gotRes, expRes);
    chk(rdPre == expPre, "R2", "pre-poll reads", rdPre, expPre);
    chk(rdPost == expPost, "R6", "post-poll reads", rdPost, expPost);
    chk(wrCount == expWr, "R8", "write count", wrCount, expWr);
    chk(!gapBad, "R3", "poll spacing", gapBad, 0);
    chk(resCount == 1, "R9", "completions", resCount, 1);
    chk(!busyAtRes, "R10", "busy at result", busyAtRes, 0);
    for (int i = 0; i < 6 && i < expWr; i++) begin
      chk(wrA[i] == 3'(i + 2), "R4", "write address", wrA[i], i + 2);
      chk(wrD[i] == expByte(i, effA, op), (op == 8'hEC) ? "R5" : "R4",
          "write data", wrD[i], expByte(i, effA, op));
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int ops [3] = '{8'h20, 8'h30, 8'hEC};
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!busy && !regRd && !regWr, "R1", "idle strobes", {busy, regRd, regWr}, 0);
    chk(!done && !faultErr && !timeoutErr, "R1", "idle results",
        {done, faultErr, timeoutErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !regRd && !regWr, "R1", "after reset release", {busy, regRd, regWr}, 0);
    // directed corners
    runCmd(8'h20, 28'h1234567, 0, 0, 0, 0, 4, 0, 0);   // R4 no busy at all
    runCmd(8'hEC, 28'hFEDCBA9, 1, 2, 0, 0, 4, 1, 0);   // R5 identify zeroes LBA
    runCmd(8'h30, 28'hABCDEF1, 5, 0, 0, 0, 3, 0, 0);   // R8 pre-phase timeout
    runCmd(8'h20, 28'h0F0F0F0, 0, 6, 0, 0, 3, 0, 0);   // R8 post-phase timeout
    runCmd(8'h30, 28'h5555555, 2, 3, 1, 0, 5, 0, 0);   // R7 fault on first post read
    runCmd(8'h20, 28'hAAAAAAA, 1, 4, 1, 2, 6, 1, 0);   // R7 fault later
    runCmd(8'h20, 28'h7654321, 0, 2, 0, 0, 4, 0, 0);   // R6 DRQ never set
    runCmd(8'h20, 28'h1111111, 3, 1, 0, 0, 5, 0, 1);   // R9 start while busy
    for (int n = 0; n < 30; n++) begin
      runCmd(8'(ops[$urandom % 3]), 28'($urandom), int'($urandom % 4),
             int'($urandom % 5), ($urandom % 4) == 0, int'($urandom % 4),
             3 + int'($urandom % 3), 1'($urandom % 2), ($urandom % 5) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule